// File: doc/BRIEF.md
# Masked byte reduction unit

This execution unit treats a 64-bit operand, normally a register pair, as eight bytes and folds them into a single 32-bit value. Each byte is included or excluded by one bit of an 8-bit byte mask. Five reductions are available: an arithmetic sum, a bitwise OR, a bitwise AND, a bitwise XOR, and a map that marks which bytes are zero.

A byte that is masked out is replaced by the neutral value of the selected reduction. That value is zero for sum, OR and XOR, and all ones for AND. The mask normally comes from the low byte of the second source operand. Only the zero-map reduction can take the mask from an 8-bit immediate instead. The 6-bit op3 code selects the reduction, and any other code raises an illegal flag.

The result is registered, so a value appears one clock after its inputs are sampled. The byte count, byte width, result width and output registering are parameters.

Top module: `mbr_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `result_o` is 0 and `illegal_o` is 0.
- R2: With op3 = 6'b101101, the result is the unsigned sum of all bytes whose mask bit is set, zero-extended to 32 bits. Eight bytes of 0xFF under mask 0xFF give 0x7F8.
- R3: With op3 = 6'b101110, the result is the OR of the enabled bytes in bits 7:0, and bits 31:8 are zero.
- R4: With op3 = 6'b101111, the result is the AND of the bytes after each disabled byte is forced to 0xFF. A zero mask gives 0x000000FF.
- R5: With op3 = 6'b111110, the result is the XOR of the enabled bytes in bits 7:0, and bits 31:8 are zero.
- R6: With op3 = 6'b111111, result bit i is 1 exactly when byte i (bits 8i+7:8i of the operand) is 0x00 and mask bit i is 1. Bits 31:8 are zero.
- R7: Mask bit i gates byte i. The mask is `src2_i[7:0]`, except in the op3 = 6'b111111 mode with `imm_sel_i` = 1, where it is `imm_byte_i`. In every other mode, `imm_sel_i` and `imm_byte_i` have no effect.
- R8: For any op3 outside the five codes, `illegal_o` is 1 and `result_o` is 0. For the five codes, `illegal_o` is 0.
- R9: The inputs sampled at one rising clock edge determine the outputs that are visible after that edge, until the next edge.
- R10: Bits 31:8 of `src2_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opnd_i | input | 64 | Operand viewed as eight bytes; byte i is bits 8i+7:8i |
| src2_i | input | 32 | Second source; bits 7:0 are the register mask |
| imm_sel_i | input | 1 | Immediate-select bit |
| imm_byte_i | input | 8 | Immediate mask, used only by the zero-map mode |
| op3_i | input | 6 | Reduction select code |
| result_o | output | 32 | Reduced value |
| illegal_o | output | 1 | op3 is not one of the five reductions |

## Verification
The bench targets several corner cases, each of which would expose a specific wrong design:
- A unit that carried the sum in eight bits would wrap on the all-0xFF sum instead of returning 0x7F8.
- A unit that filled disabled bytes with zero for AND would return 0 under an empty mask instead of 0xFF.
- A unit that honoured the immediate mask in every mode would change the OR result when the immediate differs from the register mask.
- A zero-map that ignored the mask would mark zero bytes that are disabled.
- A decoder that leaked a reduction for an unknown op3 would show a nonzero result next to the illegal flag.
- A unit that decoded the whole of `src2_i` would react to noise in bits 31:8.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

   typedef enum logic [5:0] {
      OP_SUM  = 6'b101101,
      OP_OR   = 6'b101110,
      OP_AND  = 6'b101111,
      OP_XOR  = 6'b111110,
      OP_ZPOS = 6'b111111
   } mbr_op_e;

   function automatic logic op_is_legal(input logic [5:0] code);
      case (code)
         OP_SUM, OP_OR, OP_AND, OP_XOR, OP_ZPOS: op_is_legal = 1'b1;
         default:                                op_is_legal = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/mbr_mask_sel.sv
module mbr_mask_sel #(
   parameter int NUM_BYTES = 8
) (
   input  logic [NUM_BYTES-1:0] reg_mask_i,
   input  logic [NUM_BYTES-1:0] imm_mask_i,
   input  logic                 imm_sel_i,
   input  logic                 zmap_mode_i,
   output logic [NUM_BYTES-1:0] mask_o
);
   // R7: the immediate replaces the register mask only in zero-map mode
   always_comb begin
      if (zmap_mode_i && imm_sel_i) mask_o = imm_mask_i;
      else                          mask_o = reg_mask_i;
   end
endmodule

// File: rtl/mbr_lane.sv
module mbr_lane #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              en_i,
   output logic [BYTE_W-1:0] zero_fill_o,
   output logic [BYTE_W-1:0] ones_fill_o,
   output logic              zero_hit_o
);
   always_comb begin
      zero_fill_o = en_i ? byte_i : '0;
      ones_fill_o = en_i ? byte_i : '1;
      zero_hit_o  = en_i && (byte_i == '0);
   end
endmodule

// File: rtl/mbr_reduce.sv
module mbr_reduce #(
   parameter int NUM_BYTES = 8,
   parameter int BYTE_W    = 8,
   parameter int SUM_W     = 11
) (
   input  logic [NUM_BYTES*BYTE_W-1:0] zero_fill_i,
   input  logic [NUM_BYTES*BYTE_W-1:0] ones_fill_i,
   output logic [SUM_W-1:0]            sum_o,
   output logic [BYTE_W-1:0]           or_o,
   output logic [BYTE_W-1:0]           and_o,
   output logic [BYTE_W-1:0]           xor_o
);
   always_comb begin
      sum_o = '0;
      or_o  = '0;
      and_o = '1;
      xor_o = '0;
      for (int b = 0; b < NUM_BYTES; b++) begin
         sum_o = sum_o + SUM_W'(zero_fill_i[b*BYTE_W +: BYTE_W]);
         or_o  = or_o  | zero_fill_i[b*BYTE_W +: BYTE_W];
         xor_o = xor_o ^ zero_fill_i[b*BYTE_W +: BYTE_W];
         and_o = and_o & ones_fill_i[b*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/mbr_unit.sv
module mbr_unit #(
   parameter int NUM_BYTES = 8,
   parameter int BYTE_W    = 8,
   parameter int RES_W     = 32,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_BYTES*BYTE_W-1:0] opnd_i,
   input  logic [RES_W-1:0]            src2_i,
   input  logic                        imm_sel_i,
   input  logic [NUM_BYTES-1:0]        imm_byte_i,
   input  logic [5:0]                  op3_i,
   output logic [RES_W-1:0]            result_o,
   output logic                        illegal_o
);
   import mbr_pkg::*;

   localparam int OPND_W = NUM_BYTES * BYTE_W;
   localparam int SUM_W  = BYTE_W + $clog2(NUM_BYTES);
   localparam int SUM_MAX = NUM_BYTES * ((1 << BYTE_W) - 1);

   // elaboration-time parameter checks
   if (RES_W < SUM_W) begin : g_bad_sum_w
      $error("mbr_unit: RES_W too small for the sum");
   end
   if (RES_W < NUM_BYTES || RES_W < BYTE_W) begin : g_bad_res_w
      $error("mbr_unit: RES_W too small for the zero map");
   end
   if (NUM_BYTES < 2) begin : g_bad_bytes
      $error("mbr_unit: NUM_BYTES must be at least 2");
   end

   // R10: only the low byte-mask bits of src2 are decoded
   logic unused_src2_hi;
   assign unused_src2_hi = ^src2_i[RES_W-1:NUM_BYTES];

   logic [NUM_BYTES-1:0] mask;
   logic                 zmap_mode;
   assign zmap_mode = (op3_i == OP_ZPOS);

   mbr_mask_sel #(.NUM_BYTES(NUM_BYTES)) mask_sel_i (
      .reg_mask_i  (src2_i[NUM_BYTES-1:0]),
      .imm_mask_i  (imm_byte_i),
      .imm_sel_i   (imm_sel_i),
      .zmap_mode_i (zmap_mode),
      .mask_o      (mask)
   );

   logic [OPND_W-1:0]    zero_fill;
   logic [OPND_W-1:0]    ones_fill;
   logic [NUM_BYTES-1:0] zmap;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      mbr_lane #(.BYTE_W(BYTE_W)) lane_i (
         .byte_i      (opnd_i[g*BYTE_W +: BYTE_W]),
         .en_i        (mask[g]),
         .zero_fill_o (zero_fill[g*BYTE_W +: BYTE_W]),
         .ones_fill_o (ones_fill[g*BYTE_W +: BYTE_W]),
         .zero_hit_o  (zmap[g])
      );
   end

   logic [SUM_W-1:0]  red_sum;
   logic [BYTE_W-1:0] red_or, red_and, red_xor;

   mbr_reduce #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .SUM_W(SUM_W)) reduce_i (
      .zero_fill_i (zero_fill),
      .ones_fill_i (ones_fill),
      .sum_o       (red_sum),
      .or_o        (red_or),
      .and_o       (red_and),
      .xor_o       (red_xor)
   );

   logic [RES_W-1:0] res_d;
   logic             ill_d;

   always_comb begin
      ill_d = !op_is_legal(op3_i);
      case (op3_i)
         OP_SUM:  res_d = RES_W'(red_sum);
         OP_OR:   res_d = RES_W'(red_or);
         OP_AND:  res_d = RES_W'(red_and);
         OP_XOR:  res_d = RES_W'(red_xor);
         OP_ZPOS: res_d = RES_W'(zmap);
         default: res_d = '0;
      endcase
   end

   if (REG_OUT) begin : g_reg
      logic [RES_W-1:0] res_q;
      logic             ill_q;
      logic             past_vld_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            res_q      <= '0;
            ill_q      <= 1'b0;
            past_vld_q <= 1'b0;
         end else begin
            res_q      <= res_d;
            ill_q      <= ill_d;
            past_vld_q <= 1'b1;
         end
      end
      assign result_o  = res_q;
      assign illegal_o = ill_q;

      a_r1_reset_clear: assert property (@(posedge clk_i)
         !rst_ni |=> (result_o == '0 && !illegal_o));

      a_r8_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         illegal_o |-> (result_o == '0));

      a_r8_legal_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (past_vld_q && op_is_legal($past(op3_i))) |-> !illegal_o);

      a_r2_sum_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (past_vld_q && $past(op3_i) == OP_SUM) |-> (result_o <= RES_W'(SUM_MAX)));

      a_r4_and_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (past_vld_q && $past(op3_i) == OP_AND && $past(src2_i[NUM_BYTES-1:0]) == '0)
         |-> (result_o == RES_W'({BYTE_W{1'b1}})));

      a_r6_zmap_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (past_vld_q && $past(op3_i) == OP_ZPOS) |-> (result_o[RES_W-1:NUM_BYTES] == '0));

      a_r6_zmap_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (past_vld_q && $past(op3_i) == OP_ZPOS && !$past(imm_sel_i))
         |-> ((result_o[NUM_BYTES-1:0] & ~$past(src2_i[NUM_BYTES-1:0])) == '0));
   end else begin : g_comb
      assign result_o  = res_d;
      assign illegal_o = ill_d;

      a_r8_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         illegal_o |-> (result_o == '0));
   end

endmodule

// File: tb/mbr_unit_tb_top.sv
module mbr_unit_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [63:0] opnd_i = '0;
   logic [31:0] src2_i = '0;
   logic        imm_sel_i = 1'b0;
   logic [7:0]  imm_byte_i = '0;
   logic [5:0]  op3_i = '0;
   logic [31:0] result_o;
   logic        illegal_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk_i = ~clk_i;   // 125 MHz

   mbr_unit dut_i (
      .clk_i, .rst_ni, .opnd_i, .src2_i, .imm_sel_i, .imm_byte_i, .op3_i,
      .result_o, .illegal_o
   );

   typedef struct packed {
      logic [5:0]  op3;
      logic [63:0] opnd;
      logic [31:0] src2;
      logic        isel;
      logic [7:0]  imm;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{6'b101101, 64'h0102030405060708, 32'h000000FF, 1'b0, 8'h00, 8'd2},  // R2 all bytes
      '{6'b101101, 64'hFFFFFFFFFFFFFFFF, 32'h000000FF, 1'b0, 8'h00, 8'd2},  // R2 overflow of 8 bits
      '{6'b101101, 64'h1122334455667788, 32'h000000A5, 1'b0, 8'h00, 8'd2},  // R2 sparse mask
      '{6'b101110, 64'h0102040810204080, 32'h0000003C, 1'b0, 8'h00, 8'd3},  // R3
      '{6'b101110, 64'hF00000000000000F, 32'h00000000, 1'b0, 8'h00, 8'd3},  // R3 empty mask
      '{6'b101111, 64'hFE00FDFFFBFFF7FF, 32'h000000A5, 1'b0, 8'h00, 8'd4},  // R4
      '{6'b101111, 64'h0000000000000000, 32'h00000000, 1'b0, 8'h00, 8'd4},  // R4 empty mask
      '{6'b111110, 64'h0F0F0F0F00FF00FF, 32'h000000FF, 1'b0, 8'h00, 8'd5},  // R5
      '{6'b111110, 64'h123456789ABCDEF0, 32'h00000011, 1'b0, 8'h00, 8'd5},  // R5
      '{6'b111111, 64'h00FF000012000034, 32'h000000FF, 1'b0, 8'h00, 8'd6},  // R6
      '{6'b111111, 64'h00FF000012000034, 32'h000000FF, 1'b1, 8'h0F, 8'd7},  // R7 immediate mask
      '{6'b101110, 64'h0102040810204080, 32'h0000000F, 1'b1, 8'hFF, 8'd7},  // R7 imm ignored
      '{6'b101101, 64'h0000000000000A05, 32'hFFFFFF03, 1'b0, 8'h00, 8'd10}, // R10
      '{6'b000000, 64'hFFFFFFFFFFFFFFFF, 32'h000000FF, 1'b0, 8'h00, 8'd8}   // R8
   };

   // reference computed from the requirement text
   function automatic logic [32:0] ref_model(input vec_t v);
      logic [7:0]  m;
      logic [31:0] r;
      logic [7:0]  acc;
      logic [7:0]  by;
      m = (v.op3 == 6'b111111 && v.isel) ? v.imm : v.src2[7:0];
      r = '0;
      case (v.op3)
         6'b101101: for (int i = 0; i < 8; i++) if (m[i]) r = r + 32'(v.opnd[i*8 +: 8]);
         6'b101110: begin
            acc = '0;
            for (int i = 0; i < 8; i++) if (m[i]) acc = acc | v.opnd[i*8 +: 8];
            r = 32'(acc);
         end
         6'b101111: begin
            acc = 8'hFF;
            for (int i = 0; i < 8; i++) begin
               by = m[i] ? v.opnd[i*8 +: 8] : 8'hFF;
               acc = acc & by;
            end
            r = 32'(acc);
         end
         6'b111110: begin
            acc = '0;
            for (int i = 0; i < 8; i++) if (m[i]) acc = acc ^ v.opnd[i*8 +: 8];
            r = 32'(acc);
         end
         6'b111111: for (int i = 0; i < 8; i++) r[i] = m[i] && (v.opnd[i*8 +: 8] == 8'h00);
         default: return {1'b1, 32'h0};
      endcase
      return {1'b0, r};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp,
                        input logic gil, input logic eil);
      n_checks++;
      if (got !== exp || gil !== eil) begin
         n_fail++;
         $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                  req, got, gil, exp, eil);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk_i);
      op3_i = v.op3; opnd_i = v.opnd; src2_i = v.src2;
      imm_sel_i = v.isel; imm_byte_i = v.imm;
      @(posedge clk_i);
      #2;
   endtask

   initial begin
      logic [32:0] e;
      // R1: reset state
      #3;
      check("R1", result_o, 32'h0, illegal_o, 1'b0);
      repeat (2) @(posedge clk_i);
      #2;
      check("R1", result_o, 32'h0, illegal_o, 1'b0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      // table walk (R2..R8, R10), each checked one edge after its inputs (R9)
      for (int k = 0; k < NV; k++) begin
         apply(VECS[k]);
         e = ref_model(VECS[k]);
         check($sformatf("R%0d/R9 vec%0d", VECS[k].req, k), result_o, e[31:0], illegal_o, e[32]);
      end

      // directed literal values
      apply('{6'b101101, 64'hFFFFFFFFFFFFFFFF, 32'h000000FF, 1'b0, 8'h00, 8'd2});
      check("R2 all-FF sum", result_o, 32'h000007F8, illegal_o, 1'b0);
      apply('{6'b101111, 64'h0000000000000000, 32'hFFFFFF00, 1'b1, 8'hFF, 8'd4});
      check("R4 empty mask", result_o, 32'h000000FF, illegal_o, 1'b0);
      apply('{6'b111111, 64'h00FF000012000034, 32'h000000FF, 1'b0, 8'h00, 8'd6});
      check("R6 zero map", result_o, 32'h000000B6, illegal_o, 1'b0);
      apply('{6'b111111, 64'h00FF000012000034, 32'h00000000, 1'b1, 8'h0F, 8'd7});
      check("R7 imm mask", result_o, 32'h00000006, illegal_o, 1'b0);
      apply('{6'b101110, 64'h0102040810204080, 32'h0000000F, 1'b1, 8'hFF, 8'd7});
      check("R7 imm ignored", result_o, 32'h000000F0, illegal_o, 1'b0);
      apply('{6'b101101, 64'h0000000000000A05, 32'hABCDEF03, 1'b0, 8'h00, 8'd10});
      check("R10 upper src2", result_o, 32'h0000000F, illegal_o, 1'b0);
      apply('{6'b101100, 64'h0102030405060708, 32'h000000FF, 1'b0, 8'h00, 8'd8});
      check("R8 near code", result_o, 32'h0, illegal_o, 1'b1);

      // R9: output holds until the next edge even after inputs change
      apply('{6'b111110, 64'h00000000000000AA, 32'h00000001, 1'b0, 8'h00, 8'd9});
      @(negedge clk_i);
      opnd_i = 64'h0000000000000055;
      #1;
      check("R9 hold", result_o, 32'h000000AA, illegal_o, 1'b0);
      @(posedge clk_i);
      #2;
      check("R9 update", result_o, 32'h00000055, illegal_o, 1'b0);

      // R1: reset in mid-run clears a nonzero result
      @(negedge clk_i);
      rst_ni = 1'b0;
      #1;
      check("R1 mid reset", result_o, 32'h0, illegal_o, 1'b0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: result=%h expected completion", result_o);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule